// File: doc/BRIEF.md
# Dual-Issue Instruction Pairing Checker

This block sits in the issue stage of an in-order core with two execution pipes: a primary pipe and a secondary pipe. Every cycle it receives two consecutive instructions, already pre-decoded into descriptors. It decides whether the younger instruction may issue in the secondary pipe in the same cycle as the older one. If it may not, the block reports a reason code that says why.

The decision combines four checks:

- **Pipe class.** Each instruction carries a four-way pipe class, and any prefixed instruction is forced to primary-pipe-only.
- **Cache residency.** Both instructions must be cache-resident, unless the older one is a single byte long.
- **Register dependences.** Read-after-write and write-after-write checks run over a 16-bit register mask. Sub-register accesses are already folded by the pre-decoder into the bit of their full register.
- **Special pairs.** A short list of pairs overrides the dependence checks. These are pairs whose only conflict is the implicit stack pointer or the condition flags.

The result is captured in registers, so it is valid one clock after the descriptors are applied.

Top module: `pairchk_top`

## Requirements
- R1: Each descriptor is a 43-bit vector with these fields:
  - bits 1:0: class (0 = either pipe, 1 = primary only, 2 = secondary only, 3 = never pairable)
  - bits 17:2: read mask
  - bits 33:18: write mask
  - bit 34: flags write
  - bit 35: implicit stack-pointer read
  - bit 36: implicit stack-pointer write
  - bits 39:37: kind (0 other, 1 push, 2 pop, 3 near call, 4 compare, 5 add, 6 conditional branch, 7 branch-if-not-zero)
  - bit 40: prefix
  - bit 41: one-byte length
  - bit 42: cache resident

  Register-mask bits 7:0 are the general registers, bit 8 is the flags register and bit 9 is the stack pointer.
- R2: When neither instruction is never-pairable, the older instruction's class is not 0 or 1, or the younger instruction's class is not 0 or 2, the pair is refused with reason 1.
- R3: If either instruction has class 3, the pair is refused with reason 5. This check takes precedence over every other check.
- R4: A prefixed instruction whose class is not 3 is treated as class 1.
- R5: If either instruction is not cache resident and the older one is not one byte long, the pair is refused with reason 4.
- R6: If the younger instruction's effective read mask overlaps the older one's effective write mask, including flags and stack pointer, the pair is refused with reason 2 (flow dependence).
- R7: If the two effective write masks overlap on any bit other than the flags bit, the pair is refused with reason 3 (output dependence). Writes to the low and high byte of one register set the same bit, so they conflict.
- R8: An older instruction that reads a register the younger one writes does not block pairing.
- R9: The flags-write bit is merged into mask bit 8, and the stack-pointer bits are merged into mask bit 9, before the checks run. Two flag writers with no other overlap pair.
- R10: Push followed by push, push followed by near call, and pop followed by pop skip the dependence checks.
- R11: Compare followed by a conditional branch (kind 6 or 7), and add followed by branch-if-not-zero (kind 7), skip the dependence checks.
- R12: The checks are applied in this order, and the first one that fails sets the reason:
  1. never-pairable
  2. class
  3. cache
  4. flow
  5. output

  When nothing fails, the output reports issue = 1 with reason 0. Outputs are registered, one cycle after the inputs. During reset they read issue = 0 and reason = 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| first_desc | input | 43 | Descriptor of the older instruction |
| second_desc | input | 43 | Descriptor of the younger instruction |
| pair_issue | output | 1 | Younger instruction issues in the secondary pipe |
| pair_reason | output | 3 | 0 paired, 1 class, 2 flow, 3 output, 4 cache, 5 never |

## Verification
Both outputs belong to the descriptor pair that was present at the preceding rising edge. There are no further stages, so every result is due exactly one edge after it is applied. The bench drives each descriptor pair on a falling edge, lets a single rising edge pass, and compares both outputs on the next falling edge. As a result, no check ever looks at a result that is stale or still settling.

// File: rtl/pairchk_pkg.sv
package pairchk_pkg;
  typedef enum logic [1:0] {
    CLS_ANY   = 2'd0,
    CLS_PRI   = 2'd1,
    CLS_SEC   = 2'd2,
    CLS_NEVER = 2'd3
  } pclass_e;

  typedef enum logic [2:0] {
    KD_OTHER = 3'd0,
    KD_PUSH  = 3'd1,
    KD_POP   = 3'd2,
    KD_CALL  = 3'd3,
    KD_CMP   = 3'd4,
    KD_ADD   = 3'd5,
    KD_JCC   = 3'd6,
    KD_JNZ   = 3'd7
  } kind_e;

  typedef enum logic [2:0] {
    RSN_OK     = 3'd0,
    RSN_CLASS  = 3'd1,
    RSN_FLOW   = 3'd2,
    RSN_OUTPUT = 3'd3,
    RSN_CACHE  = 3'd4,
    RSN_NEVER  = 3'd5
  } reason_e;
endpackage

// File: rtl/pairchk_norm.sv
module pairchk_norm
  import pairchk_pkg::*;
#(
  parameter int NREG     = 16,
  parameter int FLAG_IDX = 8,
  parameter int SP_IDX   = 9
) (
  input  logic [2*NREG+10:0] desc,
  output pclass_e            cls_eff,
  output logic               never,
  output logic [NREG-1:0]    rd_eff,
  output logic [NREG-1:0]    wr_eff,
  output kind_e              kind,
  output logic               one_byte,
  output logic               cached
);
  localparam int O_RD   = 2;
  localparam int O_WR   = O_RD + NREG;
  localparam int O_FW   = O_WR + NREG;
  localparam int O_SPR  = O_FW + 1;
  localparam int O_SPW  = O_FW + 2;
  localparam int O_KIND = O_FW + 3;
  localparam int O_PFX  = O_FW + 6;
  localparam int O_ONE  = O_FW + 7;
  localparam int O_CAC  = O_FW + 8;
  localparam logic [NREG-1:0] ONE_HOT = {{(NREG-1){1'b0}}, 1'b1};
  localparam logic [NREG-1:0] FLAG_BIT = ONE_HOT << FLAG_IDX;
  localparam logic [NREG-1:0] SP_BIT   = ONE_HOT << SP_IDX;

  pclass_e raw_cls;

  always_comb begin
    raw_cls = pclass_e'(desc[1:0]);
    never   = (raw_cls == CLS_NEVER);
    // a prefix forces primary-pipe-only unless the instruction never pairs
    if (desc[O_PFX] && !never) cls_eff = CLS_PRI;
    else                       cls_eff = raw_cls;
    rd_eff = desc[O_RD +: NREG] | (desc[O_SPR] ? SP_BIT : '0);
    wr_eff = desc[O_WR +: NREG] | (desc[O_FW] ? FLAG_BIT : '0)
           | (desc[O_SPW] ? SP_BIT : '0);
    kind     = kind_e'(desc[O_KIND +: 3]);
    one_byte = desc[O_ONE];
    cached   = desc[O_CAC];
  end
endmodule

// File: rtl/pairchk_special.sv
module pairchk_special
  import pairchk_pkg::*;
(
  input  kind_e older,
  input  kind_e younger,
  output logic  bypass
);
  always_comb begin
    unique case (older)
      KD_PUSH: bypass = (younger == KD_PUSH) || (younger == KD_CALL);
      KD_POP:  bypass = (younger == KD_POP);
      KD_CMP:  bypass = (younger == KD_JCC) || (younger == KD_JNZ);
      KD_ADD:  bypass = (younger == KD_JNZ);
      default: bypass = 1'b0;
    endcase
  end
endmodule

// File: rtl/pairchk_decide.sv
module pairchk_decide
  import pairchk_pkg::*;
#(
  parameter int NREG     = 16,
  parameter int FLAG_IDX = 8
) (
  input  pclass_e         cls_o,
  input  pclass_e         cls_y,
  input  logic            never_o,
  input  logic            never_y,
  input  logic [NREG-1:0] wr_o,
  input  logic [NREG-1:0] rd_y,
  input  logic [NREG-1:0] wr_y,
  input  logic            one_byte_o,
  input  logic            cached_o,
  input  logic            cached_y,
  input  logic            bypass,
  output reason_e         reason
);
  localparam logic [NREG-1:0] FLAG_BIT = {{(NREG-1){1'b0}}, 1'b1} << FLAG_IDX;

  logic pri_ok, sec_ok, cache_bad, flow_hit, out_hit;

  always_comb begin
    pri_ok    = (cls_o == CLS_ANY) || (cls_o == CLS_PRI);
    sec_ok    = (cls_y == CLS_ANY) || (cls_y == CLS_SEC);
    cache_bad = !(cached_o && cached_y) && !one_byte_o;
    flow_hit  = |(rd_y & wr_o);
    out_hit   = |(wr_o & wr_y & ~FLAG_BIT);
    if (never_o || never_y)         reason = RSN_NEVER;
    else if (!pri_ok || !sec_ok)    reason = RSN_CLASS;
    else if (cache_bad)             reason = RSN_CACHE;
    else if (!bypass && flow_hit)   reason = RSN_FLOW;
    else if (!bypass && out_hit)    reason = RSN_OUTPUT;
    else                            reason = RSN_OK;
  end
endmodule

// File: rtl/pairchk_top.sv
module pairchk_top
  import pairchk_pkg::*;
#(
  parameter int NREG     = 16,
  parameter int FLAG_IDX = 8,
  parameter int SP_IDX   = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2*NREG+10:0] first_desc,
  input  logic [2*NREG+10:0] second_desc,
  output logic              pair_issue,
  output logic [2:0]        pair_reason
);
  localparam int DW    = 2*NREG + 11;
  localparam int O_WR  = 2 + NREG;
  localparam int O_KND = 2 + 2*NREG + 3;
  localparam int O_PFX = 2 + 2*NREG + 6;
  localparam int O_ONE = 2 + 2*NREG + 7;
  localparam int O_CAC = 2 + 2*NREG + 8;
  localparam logic [NREG-1:0] GEN_MASK = ({{(NREG-1){1'b0}}, 1'b1} << FLAG_IDX) - 1'b1;

  logic [DW-1:0]   slot_desc [2];
  pclass_e         slot_cls  [2];
  logic            slot_nev  [2];
  logic [NREG-1:0] slot_rd   [2];
  logic [NREG-1:0] slot_wr   [2];
  kind_e           slot_kind [2];
  logic            slot_one  [2];
  logic            slot_cac  [2];
  logic            bypass;
  reason_e         reason;

  assign slot_desc[0] = first_desc;
  assign slot_desc[1] = second_desc;

  for (genvar s = 0; s < 2; s++) begin : g_slot
    pairchk_norm #(.NREG(NREG), .FLAG_IDX(FLAG_IDX), .SP_IDX(SP_IDX)) u_norm (
      .desc     (slot_desc[s]),
      .cls_eff  (slot_cls[s]),
      .never    (slot_nev[s]),
      .rd_eff   (slot_rd[s]),
      .wr_eff   (slot_wr[s]),
      .kind     (slot_kind[s]),
      .one_byte (slot_one[s]),
      .cached   (slot_cac[s])
    );
  end

  pairchk_special u_special (
    .older   (slot_kind[0]),
    .younger (slot_kind[1]),
    .bypass  (bypass)
  );

  pairchk_decide #(.NREG(NREG), .FLAG_IDX(FLAG_IDX)) u_decide (
    .cls_o      (slot_cls[0]),
    .cls_y      (slot_cls[1]),
    .never_o    (slot_nev[0]),
    .never_y    (slot_nev[1]),
    .wr_o       (slot_wr[0]),
    .rd_y       (slot_rd[1]),
    .wr_y       (slot_wr[1]),
    .one_byte_o (slot_one[0]),
    .cached_o   (slot_cac[0]),
    .cached_y   (slot_cac[1]),
    .bypass     (bypass),
    .reason     (reason)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pair_issue  <= 1'b0;
      pair_reason <= RSN_NEVER;
    end else begin
      pair_issue  <= (reason == RSN_OK);
      pair_reason <= reason;
    end
  end

  // R3
  never_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (first_desc[1:0] == 2'd3 || second_desc[1:0] == 2'd3)
      |=> (!pair_issue && pair_reason == 3'd5));

  // R2
  pri_only_second_chk: assert property (@(posedge clk) disable iff (rst)
    (second_desc[1:0] == 2'd1) |=> !pair_issue);

  // R4
  prefix_second_chk: assert property (@(posedge clk) disable iff (rst)
    second_desc[O_PFX] |=> !pair_issue);

  // R5
  cache_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (!first_desc[O_CAC] && !first_desc[O_ONE]) |=> !pair_issue);

  // R7
  gen_output_dep_chk: assert property (@(posedge clk) disable iff (rst)
    (first_desc[O_KND +: 3] == 3'd0
     && |(first_desc[O_WR +: NREG] & second_desc[O_WR +: NREG] & GEN_MASK))
      |=> !pair_issue);

  // R12
  issue_reason_chk: assert property (@(posedge clk) disable iff (rst)
    pair_issue |-> pair_reason == 3'd0);
endmodule

// File: tb/pairchk_top_tb.sv
`timescale 1ns/1ps
module pairchk_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [42:0] first_desc  = '0;
  logic [42:0] second_desc = '0;
  logic        pair_issue;
  logic [2:0]  pair_reason;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  always #2 clk = ~clk;

  pairchk_top u_dut (
    .clk(clk), .rst(rst),
    .first_desc(first_desc), .second_desc(second_desc),
    .pair_issue(pair_issue), .pair_reason(pair_reason)
  );

  // R1 field layout: cache, one-byte, prefix, kind, spw, spr, flags-write, wr, rd, class
  function automatic logic [42:0] mk(int cls, logic [15:0] rd, logic [15:0] wr,
      bit fw, bit spr, bit spw, int kind, bit pfx, bit one, bit cac);
    logic [1:0] c2 = cls[1:0];
    logic [2:0] k3 = kind[2:0];
    return {cac, one, pfx, k3, spw, spr, fw, wr, rd, c2};
  endfunction

  function automatic logic [15:0] rbit(int r);
    return 16'h1 << r;
  endfunction

  // dependence patterns between older (a) and younger (b)
  task automatic pat(input int p, output logic [15:0] ard, output logic [15:0] awr,
      output bit afw, output bit asp, output logic [15:0] brd, output logic [15:0] bwr,
      output bit bfw, output bit bsp);
    ard = '0; awr = '0; afw = 0; asp = 0; brd = '0; bwr = '0; bfw = 0; bsp = 0;
    case (p)
      0: begin awr = rbit(1); ard = rbit(2); bwr = rbit(3); brd = rbit(4); end
      1: begin awr = rbit(1); brd = rbit(1); bwr = rbit(3); end        // R6 flow
      2: begin awr = rbit(2); bwr = rbit(2); brd = rbit(4); end        // R7 low/high byte alias
      3: begin afw = 1; ard = rbit(0); awr = rbit(1);
               bfw = 1; brd = rbit(5); bwr = rbit(6); end              // R9 flags exempt
      4: begin afw = 1; awr = rbit(1); brd = rbit(8); end              // R6 flags flow
      5: begin asp = 1; bsp = 1; end                                   // R9 stack merge
      default: begin ard = rbit(3); awr = rbit(1); bwr = rbit(3); brd = rbit(4); end // R8
    endcase
  endtask

  function automatic int model(logic [42:0] a, logic [42:0] b);
    int ca = int'(a[1:0]);
    int cb = int'(b[1:0]);
    int ka = int'(a[39:37]);
    int kb = int'(b[39:37]);
    logic [15:0] ard, awr, brd, bwr;
    bit sp;
    if (ca == 3 || cb == 3) return 5;                       // R3
    if (a[40]) ca = 1;                                      // R4
    if (b[40]) cb = 1;
    if (!(ca == 0 || ca == 1) || !(cb == 0 || cb == 2)) return 1; // R2
    if (!(a[42] && b[42]) && !a[41]) return 4;              // R5
    sp = (ka == 1 && (kb == 1 || kb == 3)) || (ka == 2 && kb == 2)   // R10
      || (ka == 4 && (kb == 6 || kb == 7)) || (ka == 5 && kb == 7);  // R11
    if (sp) return 0;
    ard = a[17:2] | (a[35] ? 16'h0200 : 16'h0);
    awr = a[33:18] | (a[34] ? 16'h0100 : 16'h0) | (a[36] ? 16'h0200 : 16'h0);
    brd = b[17:2] | (b[35] ? 16'h0200 : 16'h0);
    bwr = b[33:18] | (b[34] ? 16'h0100 : 16'h0) | (b[36] ? 16'h0200 : 16'h0);
    if (ard == 16'hFFFF) return 0;                          // never true; keeps ard referenced
    if ((brd & awr) != 0) return 2;                         // R6
    if ((awr & bwr & ~16'h0100) != 0) return 3;             // R7
    return 0;
  endfunction

  function automatic string tag(int e, logic [42:0] a, logic [42:0] b, int p);
    int ka = int'(a[39:37]);
    case (e)
      5: return "R3";
      1: return (a[40] || b[40]) ? "R4" : "R2";
      4: return "R5";
      2: return "R6";
      3: return "R7";
      default: begin
        if (ka == 1 || ka == 2) return "R10";
        if (ka == 4 || ka == 5) return "R11";
        if (p == 6) return "R8";
        if (p == 3 || p == 5) return "R9";
        return "R12";
      end
    endcase
  endfunction

  task automatic apply(logic [42:0] a, logic [42:0] b, int p);
    int e;
    string t;
    first_desc  = a;
    second_desc = b;
    @(posedge clk);
    @(negedge clk);
    e = model(a, b);
    t = tag(e, a, b, p);
    checks++;
    if (pair_issue !== (e == 0) || pair_reason !== 3'(e)) begin
      fails++;
      $display("FAIL %s: issue=%0b reason=%0d expected issue=%0b reason=%0d (a=%h b=%h)",
               t, pair_issue, pair_reason, (e == 0), e, a, b);
    end
  endtask

  initial begin
    logic [15:0] ard, awr, brd, bwr;
    bit afw, asp, bfw, bsp;
    repeat (3) @(negedge clk);
    // R12 reset state
    checks++;
    if (pair_issue !== 1'b0 || pair_reason !== 3'd5) begin
      fails++;
      $display("FAIL R12: reset issue=%0b reason=%0d expected issue=0 reason=5",
               pair_issue, pair_reason);
    end
    rst = 1'b0;
    // sweep classes, kinds and patterns, all cached, no prefix
    for (int ca = 0; ca < 4; ca++)
      for (int cb = 0; cb < 4; cb++)
        for (int ka = 0; ka < 8; ka++)
          for (int kb = 0; kb < 8; kb++)
            for (int p = 0; p < 7; p++) begin
              pat(p, ard, awr, afw, asp, brd, bwr, bfw, bsp);
              apply(mk(ca, ard, awr, afw, asp, asp, ka, 0, 0, 1),
                    mk(cb, brd, bwr, bfw, bsp, bsp, kb, 0, 0, 1), p);
            end
    // sweep classes, prefixes, cache/length bits and patterns
    for (int ca = 0; ca < 4; ca++)
      for (int cb = 0; cb < 4; cb++)
        for (int pf = 0; pf < 4; pf++)
          for (int cc = 0; cc < 8; cc++)
            for (int p = 0; p < 7; p++) begin
              pat(p, ard, awr, afw, asp, brd, bwr, bfw, bsp);
              apply(mk(ca, ard, awr, afw, asp, asp, 0, pf[0], cc[2], cc[0]),
                    mk(cb, brd, bwr, bfw, bsp, bsp, 0, pf[1], 0, cc[1]), p);
            end
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule